// File: doc/BRIEF.md
# Three-Tier Shared Bus Arbiter

This block decides which agent owns a shared system bus. The requesters fall into three tiers of fixed precedence. The top tier holds the DMA channels together with a memory refresh requester that lives inside the arbiter. The middle tier is the host processor. The bottom tier is a group of add-in bus masters, such as a second processor or a network controller. Each agent raises its own request line and gets back a grant line. Exactly one grant is high at any time.

A grant is never taken away from an owner while it still requests. Once the owner lets go, the arbiter picks again on the next clock edge. It takes the highest tier that has a request. Inside the top tier and the bottom tier, a rotating pointer makes sure that every member gets a turn. When nobody asks, the processor is parked on the bus. Refresh is paced by an interval counter whose period comes from an input. Each refresh holds the bus for a fixed number of cycles, so the masters never run refresh cycles themselves.

Top module: `tier_bus_arbiter`

## Requirements
- R1: Exactly one of the grant outputs (`dma_gnt` bits, `rfsh_gnt`, `cpu_gnt`, `mst_gnt` bits) is high in every cycle.
- R2: During and right after reset, `cpu_gnt` is 1 and every other grant is 0.
- R3: While the current owner keeps its request high, the grant outputs do not change at the next clock edge.
- R4: When the owner's request is low at a clock edge, the new owner is chosen by tier. The top tier (any DMA request or a pending refresh) comes first, then `cpu_req`, then the add-in masters.
- R5: Inside the top tier, the slots are DMA channel 0 to N_DMA-1 followed by refresh as slot N_DMA. Inside the master tier, the slots are masters 0 to N_MST-1. The winner is the first requesting slot at or after the tier's pointer, counting upward with wrap. The pointer then moves to the slot just after the winner. Both pointers start at 0.
- R6: If no request and no refresh are pending at a rearbitration edge, the grant goes to the processor.
- R7: With a nonzero `refresh_period` P and the bus otherwise idle, `rfsh_gnt` rises once every P cycles. Each time it stays high for exactly RFSH_CYC cycles.
- R8: A `refresh_period` of 0 stops the interval counter, and no new refresh is raised.
- R9: A pending refresh does not preempt a holding owner. It is granted at the first edge after the owner drops its request, ahead of any requesting master.
- R10: An add-in master that drops its request loses its grant at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_period | input | CNT_W | Refresh interval in cycles; 0 disables refresh |
| dma_req | input | N_DMA | DMA channel requests |
| cpu_req | input | 1 | Host processor request |
| mst_req | input | N_MST | Add-in bus master requests |
| dma_gnt | output | N_DMA | DMA channel grants |
| rfsh_gnt | output | 1 | High while a refresh owns the bus |
| cpu_gnt | output | 1 | Host processor grant |
| mst_gnt | output | N_MST | Add-in master grants |

## Verification
The cycle assertions check several properties on every cycle: that the grant is one-hot, that a grant holds while its owner requests, that an idle bus parks on the processor, that a master grant appears only when no higher tier asked, that a master loses its grant right after it releases, and that each refresh is exactly RFSH_CYC cycles long. Some behaviour only the bench scenarios can show. These include the rotation order inside each tier, the spacing between refreshes, a refresh waiting behind a holding owner, and the silence of the refresh path when the period is zero. For these, a reference model checks the exact owner on every cycle across an exhaustive sweep of request patterns and a long random run.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Which tier wins a rearbitration edge.
   typedef enum logic [1:0] {
      TIER_TOP  = 2'd0,
      TIER_CPU  = 2'd1,
      TIER_MST  = 2'd2,
      TIER_IDLE = 2'd3
   } tier_sel_e;

   // Width of an index into a set of n slots, never below one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/arb_rr_tier.sv
module arb_rr_tier #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] pick,
   output logic         any
);
   localparam int PW = arb_pkg::idx_w(N);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] sel_idx;
   logic          found;

   // Search upward from the pointer, wrapping once.
   always_comb begin
      found   = 1'b0;
      sel_idx = '0;
      for (int i = 0; i < N; i++) begin
         int s;
         s = int'(ptr_q) + i;
         if (s >= N) s = s - N;
         if (!found && req[s]) begin
            found   = 1'b1;
            sel_idx = PW'(s);
         end
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_slot
      assign pick[k] = found && (sel_idx == PW'(k));
   end

   assign any = found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv && found)
         ptr_q <= (sel_idx == PW'(N - 1)) ? '0 : sel_idx + 1'b1;
   end

endmodule

// File: rtl/arb_refresh_timer.sv
module arb_refresh_timer #(
   parameter int CNT_W    = 10,
   parameter int RFSH_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic             granted,
   output logic             req
);
   localparam int HW = arb_pkg::idx_w(RFSH_CYC);
   localparam logic [HW-1:0] HOLD_LAST = HW'(RFSH_CYC - 1);

   logic [CNT_W-1:0] ctr_q;
   logic [HW-1:0]    hold_q;
   logic             pend_q;
   logic             tick;

   assign tick = (period != '0) && (ctr_q >= period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctr_q <= '0;
      else if (period == '0 || tick)
         ctr_q <= '0;
      else
         ctr_q <= ctr_q + 1'b1;
   end

   // A tick sets the pending flag; being granted clears it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (tick)
         pend_q <= 1'b1;
      else if (granted)
         pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (granted)
         hold_q <= hold_q + 1'b1;
      else
         hold_q <= '0;
   end

   // While owning the bus the request stays high until the last cycle.
   assign req = granted ? (hold_q != HOLD_LAST) : pend_q;

endmodule

// File: rtl/tier_bus_arbiter.sv
module tier_bus_arbiter #(
   parameter int N_DMA    = 4,
   parameter int N_MST    = 4,
   parameter int CNT_W    = 10,
   parameter int RFSH_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] refresh_period,
   input  logic [N_DMA-1:0] dma_req,
   input  logic             cpu_req,
   input  logic [N_MST-1:0] mst_req,
   output logic [N_DMA-1:0] dma_gnt,
   output logic             rfsh_gnt,
   output logic             cpu_gnt,
   output logic [N_MST-1:0] mst_gnt
);
   import arb_pkg::*;

   localparam int NT = N_DMA + 1;   // DMA slots plus the refresh slot

   if (N_DMA < 1 || N_MST < 1 || RFSH_CYC < 1 || CNT_W < 2) begin : g_bad_cfg
      $error("tier_bus_arbiter: unsupported parameter set");
   end

   logic [NT-1:0]    top_gnt_q;
   logic             cpu_gnt_q;
   logic [N_MST-1:0] mst_gnt_q;

   logic             rf_req;
   logic [NT-1:0]    top_req;
   logic [NT-1:0]    top_pick;
   logic             top_any;
   logic [N_MST-1:0] mst_pick;
   logic             mst_any;
   logic             hold;
   tier_sel_e        sel;

   arb_refresh_timer #(
      .CNT_W   (CNT_W),
      .RFSH_CYC(RFSH_CYC)
   ) u_rfsh (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (refresh_period),
      .granted(top_gnt_q[N_DMA]),
      .req    (rf_req)
   );

   assign top_req = {rf_req, dma_req};

   arb_rr_tier #(.N(NT)) u_top (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (top_req),
      .adv  (sel == TIER_TOP),
      .pick (top_pick),
      .any  (top_any)
   );

   arb_rr_tier #(.N(N_MST)) u_mst (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (mst_req),
      .adv  (sel == TIER_MST),
      .pick (mst_pick),
      .any  (mst_any)
   );

   // The owner keeps the bus while its own request line stays high.
   assign hold = (|(top_gnt_q & top_req)) |
                 (cpu_gnt_q & cpu_req)    |
                 (|(mst_gnt_q & mst_req));

   always_comb begin
      if (hold)         sel = TIER_IDLE;
      else if (top_any) sel = TIER_TOP;
      else if (cpu_req) sel = TIER_CPU;
      else if (mst_any) sel = TIER_MST;
      else              sel = TIER_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_gnt_q <= '0;
         cpu_gnt_q <= 1'b1;
         mst_gnt_q <= '0;
      end else if (!hold) begin
         top_gnt_q <= (sel == TIER_TOP) ? top_pick : '0;
         cpu_gnt_q <= (sel == TIER_CPU) || (sel == TIER_IDLE);
         mst_gnt_q <= (sel == TIER_MST) ? mst_pick : '0;
      end
   end

   assign dma_gnt  = top_gnt_q[N_DMA-1:0];
   assign rfsh_gnt = top_gnt_q[N_DMA];
   assign cpu_gnt  = cpu_gnt_q;
   assign mst_gnt  = mst_gnt_q;

endmodule

// File: rtl/tier_bus_arbiter_chk.sv
module tier_bus_arbiter_chk #(
   parameter int N_DMA    = 4,
   parameter int N_MST    = 4,
   parameter int RFSH_CYC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_DMA-1:0] dma_req,
   input logic             cpu_req,
   input logic [N_MST-1:0] mst_req,
   input logic [N_DMA-1:0] dma_gnt,
   input logic             rfsh_gnt,
   input logic             cpu_gnt,
   input logic [N_MST-1:0] mst_gnt,
   input logic             rf_req_i
);
   logic [15:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (rfsh_gnt) run_q <= run_q + 1'b1;
      else               run_q <= '0;
   end

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({mst_gnt, cpu_gnt, rfsh_gnt, dma_gnt}));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(dma_gnt & dma_req)) || (cpu_gnt && cpu_req) || (|(mst_gnt & mst_req)))
      |=> $stable({mst_gnt, cpu_gnt, rfsh_gnt, dma_gnt}));

   p_tier_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|mst_gnt) && (cpu_req || (|dma_req)))
      |=> !(|mst_gnt));

   p_idle_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|dma_req) && !cpu_req && !(|mst_req) && !rf_req_i)
      |=> cpu_gnt);

   p_rfsh_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_gnt |-> (run_q < 16'(RFSH_CYC)));

   p_rfsh_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rfsh_gnt && run_q == 16'(RFSH_CYC - 1)) |=> !rfsh_gnt);

   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mst_gnt & ~mst_req)) |=> !(|(mst_gnt & $past(mst_gnt))));

endmodule

bind tier_bus_arbiter tier_bus_arbiter_chk #(
   .N_DMA   (N_DMA),
   .N_MST   (N_MST),
   .RFSH_CYC(RFSH_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dma_req (dma_req),
   .cpu_req (cpu_req),
   .mst_req (mst_req),
   .dma_gnt (dma_gnt),
   .rfsh_gnt(rfsh_gnt),
   .cpu_gnt (cpu_gnt),
   .mst_gnt (mst_gnt),
   .rf_req_i(rf_req)
);

// File: tb/tier_bus_arbiter_bench.sv
module tier_bus_arbiter_bench;
   localparam int ND = 2;
   localparam int NM = 3;
   localparam int NT = ND + 1;
   localparam int CW = 8;
   localparam int RC = 3;
   localparam int VW = ND + 2 + NM;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] refresh_period = '0;
   logic [ND-1:0] dma_req = '0;
   logic          cpu_req = 1'b0;
   logic [NM-1:0] mst_req = '0;
   logic [ND-1:0] dma_gnt;
   logic          rfsh_gnt;
   logic          cpu_gnt;
   logic [NM-1:0] mst_gnt;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   int    e_own;
   int    e_pt;
   int    e_pm;
   string e_why;

   always #10 clk = ~clk;

   tier_bus_arbiter #(
      .N_DMA(ND), .N_MST(NM), .CNT_W(CW), .RFSH_CYC(RC)
   ) u_tier_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .refresh_period(refresh_period),
      .dma_req(dma_req), .cpu_req(cpu_req), .mst_req(mst_req),
      .dma_gnt(dma_gnt), .rfsh_gnt(rfsh_gnt), .cpu_gnt(cpu_gnt), .mst_gnt(mst_gnt)
   );

   function automatic logic [VW-1:0] gvec();
      return {mst_gnt, cpu_gnt, rfsh_gnt, dma_gnt};
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Reference model of one rearbitration edge (owner codes follow grant vector bits).
   task automatic model_step(input logic [ND-1:0] d, input logic c, input logic [NM-1:0] m);
      bit hold;
      bit done;
      hold = (e_own < ND && d[e_own]) || (e_own == ND + 1 && c) ||
             (e_own >= ND + 2 && m[e_own - ND - 2]);
      done = 1'b0;
      if (hold) e_why = "R3 hold";
      else if (|d) begin
         for (int i = 0; i < NT; i++) begin
            int s;
            s = (e_pt + i) % NT;
            if (!done && s < ND && d[s]) begin
               done = 1'b1; e_own = s; e_pt = (s + 1) % NT;
            end
         end
         e_why = "R4 R5 top tier";
      end else if (c) begin
         e_own = ND + 1; e_why = "R4 cpu tier";
      end else if (|m) begin
         for (int i = 0; i < NM; i++) begin
            int s;
            s = (e_pm + i) % NM;
            if (!done && m[s]) begin
               done = 1'b1; e_own = ND + 2 + s; e_pm = (s + 1) % NM;
            end
         end
         e_why = "R5 R10 master tier";
      end else begin
         e_own = ND + 1; e_why = "R6 idle";
      end
   endtask

   // Check the current cycle, then apply the next request pattern.
   task automatic cycle(input logic [ND-1:0] d, input logic c, input logic [NM-1:0] m);
      logic [VW-1:0] exp;
      @(negedge clk);
      exp = VW'(1) << e_own;
      check(gvec() == exp, e_why, 32'(gvec()), 32'(exp));
      check($onehot(gvec()), "R1 onehot", 32'(gvec()), 32'(exp));
      dma_req = d; cpu_req = c; mst_req = m;
      model_step(d, c, m);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
         $finish;
      end
   end

   initial begin
      logic [ND-1:0] d;
      logic          c;
      logic [NM-1:0] m;
      int t1, t2, len, cyc, hits;

      e_own = ND + 1; e_pt = 0; e_pm = 0; e_why = "R2 reset";
      repeat (3) @(negedge clk);
      check(gvec() == VW'(1) << (ND + 1), "R2 in reset", 32'(gvec()), 32'(1 << (ND + 1)));
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(gvec() == VW'(1) << (ND + 1), "R2 after reset", 32'(gvec()), 32'(1 << (ND + 1)));

      // Exhaustive sweep of request patterns (R3 R4 R5 R6 R10), refresh off (R8).
      for (int p = 0; p < (1 << (ND + 1 + NM)); p++) begin
         d = p[ND-1:0]; c = p[ND]; m = p[ND+1 +: NM];
         cycle(d, c, m);
         cycle(d, c, m);
         cycle('0, 1'b0, '0);
      end
      // Random sweep with sticky requests.
      d = '0; c = 1'b0; m = '0;
      for (int k = 0; k < 3000; k++) begin
         d = d ^ ND'($urandom & $urandom);
         c = c ^ ((($urandom % 4) == 0) ? 1'b1 : 1'b0);
         m = m ^ NM'($urandom & $urandom);
         cycle(d, c, m);
      end
      cycle('0, 1'b0, '0);
      cycle('0, 1'b0, '0);
      check(rfsh_gnt == 1'b0, "R8 no refresh with period 0", 32'(rfsh_gnt), 0);

      // R7: refresh spacing and length on an idle bus.
      refresh_period = CW'(10);
      cyc = 0; t1 = -1; t2 = -1; len = 0;
      while (t2 < 0 && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (rfsh_gnt && t1 >= 0 && len > 0 && t2 < 0 && !(cyc == t1 + len)) t2 = cyc;
         if (rfsh_gnt && t1 < 0) t1 = cyc;
         if (rfsh_gnt && t1 >= 0 && t2 < 0 && cyc == t1 + len) len++;
      end
      check(len == RC, "R7 refresh length", 32'(len), RC);
      check(t2 - t1 == 10, "R7 refresh spacing", 32'(t2 - t1), 10);

      // R9: refresh waits behind a holding processor.
      cpu_req = 1'b1;
      while (rfsh_gnt) @(negedge clk);
      check(cpu_gnt == 1'b1, "R4 cpu after refresh", 32'(cpu_gnt), 1);
      hits = 0;
      for (int k = 0; k < 25; k++) begin
         @(negedge clk);
         if (rfsh_gnt || !cpu_gnt) hits++;
      end
      check(hits == 0, "R9 no preemption", 32'(hits), 0);
      cpu_req = 1'b0; mst_req = 3'b001;
      @(negedge clk);
      check(rfsh_gnt == 1'b1, "R9 refresh first after release", 32'(gvec()), 32'(1 << ND));
      repeat (RC) @(negedge clk);
      check(mst_gnt == 3'b001, "R4 master after refresh", 32'(gvec()), 32'(1 << (ND + 2)));

      // R8: period 0 stops refresh after any pending one drains.
      refresh_period = '0; mst_req = '0;
      repeat (15) @(negedge clk);
      hits = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (rfsh_gnt) hits++;
      end
      check(hits == 0, "R8 refresh disabled", 32'(hits), 0);
      check(cpu_gnt == 1'b1, "R6 idle parks on cpu", 32'(gvec()), 32'(1 << (ND + 1)));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule